// File: doc/BRIEF.md
# Configurable Multifunction Pin Multiplexer

This block routes a bank of general-purpose digital pins to and from the inside of a chip. Each pin has one 8-bit configuration register. The top bit of that register chooses the pin's direction. The low seven bits hold a sparse function code. A pin in output mode drives one selected internal status flag, a constant, or a free-running divided system clock. A pin in input mode passes its synchronised level to one internal control line. One input code drives two controls at once.

Software writes and reads the registers through a simple synchronous register port. The status flags that a pin can monitor come in on a plain vector, and the controls that the pins drive leave on another plain vector. When several input pins select the same control, the pin with the lowest index drives it and the others are ignored. Each pad driver gets an output value, an output enable and an input sample.

Top module: `mfpin_mux`

## Requirements
- R1: Registers sit at addresses 0 to NPINS-1, one per pin. A write on `cfg_we` takes effect at the next rising clock edge. `cfg_rdata` shows the register selected by `cfg_addr`. Every register resets to 0x00, which makes the pin an input with code 0.
- R2: `pin_oe[i]` is 1 exactly when bit 7 of register i is 1 (output mode). It is 0 when bit 7 is 0 (input mode).
- R3: In output mode, code 0 drives `pin_out` to 0 and code 1 drives it to 1.
- R4: In output mode, code 2 drives the system clock divided by 32, taken from a 5-bit counter that reset clears. The output is low for the first 16 cycles after reset, then high for 16 cycles, and this repeats.
- R5: In output mode, codes 16..26 drive `status_in[code-16]` (the loop-state flags). Codes 32..35 drive `status_in[11+code-32]` (the reference fault flags). Codes 48..51 drive `status_in[15+code-48]` (the reference valid flags). Codes 64..67 drive `status_in[19+code-64]` (the active-reference flags).
- R6: In output mode, every other code (3..15, 27..31, 36..47, 52..63, 68..127) drives 0.
- R7: In input mode, codes map to control bits as follows. Codes 1..5 drive `ctl_out[code-1]`. Codes 16..20 drive `ctl_out[5+code-16]`. Codes 32..35 drive `ctl_out[10+code-32]`. Codes 48..51 drive `ctl_out[14+code-48]`. Code 64 drives `ctl_out[18]` (enable clock output 0). Code 65 drives `ctl_out[19]` (enable clock output 1). Code 69 drives `ctl_out[20]` (output sync request).
- R8: In input mode, code 68 drives both `ctl_out[18]` and `ctl_out[19]` from the same pin.
- R9: In input mode, codes 0, 66, 67 and all other codes not listed in R7 and R8 drive no control. A pin in output mode drives no control. A control line that no input pin selects is held at 0.
- R10: When several input pins select the same control bit, that bit follows the lowest-index pin among them, and the other pins have no effect on it.
- R11: A pin level passes through a two-flop synchronizer. A change on `pin_in` sampled at one clock edge reaches `ctl_out` after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (3) | Register address, which is the pin index |
| cfg_wdata | input | 8 | Write data: bit 7 is the direction, bits 6:0 are the function code |
| cfg_rdata | output | 8 | Contents of the addressed register |
| status_in | input | 23 | Internal status flags that output pins can monitor |
| ctl_out | output | 21 | Internal control lines that input pins drive |
| pin_in | input | NPINS (8) | Sampled pad levels |
| pin_out | output | NPINS (8) | Pad output values |
| pin_oe | output | NPINS (8) | Pad output enables |

## Verification
The bench sweeps all 128 codes on every pin in both directions, so a sparse decode that shifts a range by one, or lets a gap code leak a status flag or a control, shows up as a wrong bit. Conflicting-pin cases put the same control, and the dual-enable code against a single-enable code, on a low and a high pin with opposite levels. A design that lets the highest pin win, or ORs the pins together, gives the wrong level. The synchronizer latency is checked one edge early and on time, which catches a design that skips a flop or adds one. The divided clock is compared against a cycle count kept since reset, so a wrong divide ratio, a wrong duty cycle or a counter that reset does not clear all fail.

// File: rtl/mfpin_pkg.sv
package mfpin_pkg;

   localparam int CFG_W     = 8;
   localparam int CODE_W    = 7;

   // status vector layout
   localparam int N_LOOP_ST = 11;
   localparam int N_REF     = 4;
   localparam int ST_FAULT  = N_LOOP_ST;
   localparam int ST_VALID  = ST_FAULT + N_REF;
   localparam int ST_ACTV   = ST_VALID + N_REF;
   localparam int NSTAT     = ST_ACTV + N_REF;

   // control vector layout
   localparam int N_GEN_IN  = 5;
   localparam int N_LOOP_IN = 5;
   localparam int CT_LOOP   = N_GEN_IN;
   localparam int CT_MON    = CT_LOOP + N_LOOP_IN;
   localparam int CT_VTO    = CT_MON + N_REF;
   localparam int CT_EN0    = CT_VTO + N_REF;
   localparam int CT_EN1    = CT_EN0 + 1;
   localparam int CT_SYNC   = CT_EN1 + 1;
   localparam int NCTL      = CT_SYNC + 1;

   // code anchors shared by the input and output maps
   localparam int C_BANK1   = 16;
   localparam int C_BANK2   = 32;
   localparam int C_BANK3   = 48;
   localparam int C_BANK4   = 64;
   localparam int C_EN_BOTH = 68;
   localparam int C_SYNC    = 69;

   typedef logic [CFG_W-1:0] cfg_t;

   function automatic logic [NCTL-1:0] in_target(input logic [CODE_W-1:0] code);
      logic [NCTL-1:0] one;
      logic [NCTL-1:0] m;
      int c;
      one = NCTL'(1);
      m   = '0;
      c   = int'(code);
      if (c >= 1 && c <= N_GEN_IN)
         m = one << (c - 1);
      else if (c >= C_BANK1 && c < C_BANK1 + N_LOOP_IN)
         m = one << (CT_LOOP + c - C_BANK1);
      else if (c >= C_BANK2 && c < C_BANK2 + N_REF)
         m = one << (CT_MON + c - C_BANK2);
      else if (c >= C_BANK3 && c < C_BANK3 + N_REF)
         m = one << (CT_VTO + c - C_BANK3);
      else if (c == C_BANK4)
         m = one << CT_EN0;
      else if (c == C_BANK4 + 1)
         m = one << CT_EN1;
      else if (c == C_EN_BOTH)
         m = (one << CT_EN0) | (one << CT_EN1);
      else if (c == C_SYNC)
         m = one << CT_SYNC;
      return m;
   endfunction

endpackage

// File: rtl/mfpin_cfg_regs.sv
module mfpin_cfg_regs
   import mfpin_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [CFG_W-1:0]        wdata,
   output logic [CFG_W-1:0]        rdata,
   output logic [NPINS*CFG_W-1:0]  cfg_flat
);

   cfg_t regs [NPINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPINS; i++) regs[i] <= '0;
      end else if (we && (int'(addr) < NPINS)) begin
         regs[addr] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (int'(addr) < NPINS) rdata = regs[addr];
   end

   for (genvar g = 0; g < NPINS; g++) begin : g_flat
      assign cfg_flat[g*CFG_W +: CFG_W] = regs[g];
   end

endmodule

// File: rtl/mfpin_clkdiv.sv
module mfpin_clkdiv #(
   parameter int LOG2_DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic div_q
);

   logic [LOG2_DIV-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign div_q = cnt[LOG2_DIV-1];

endmodule

// File: rtl/mfpin_sync.sv
module mfpin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage[s] <= '0;
      end else begin
         stage[0] <= d;
         for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      end
   end

   assign q = stage[STAGES-1];

endmodule

// File: rtl/mfpin_out_sel.sv
module mfpin_out_sel
   import mfpin_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic [NPINS*CFG_W-1:0] cfg_flat,
   input  logic [NSTAT-1:0]       status_in,
   input  logic                   div_q,
   output logic [NPINS-1:0]       pin_out,
   output logic [NPINS-1:0]       pin_oe
);

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      cfg_t            cfg;
      int              c;
      logic [NSTAT-1:0] sh;
      logic            v;

      assign cfg = cfg_flat[g*CFG_W +: CFG_W];
      assign pin_oe[g] = cfg[CFG_W-1];

      always_comb begin
         c  = int'(cfg[CODE_W-1:0]);
         sh = '0;
         v  = 1'b0;
         if (c == 1)
            v = 1'b1;
         else if (c == 2)
            v = div_q;
         else if (c >= C_BANK1 && c < C_BANK1 + N_LOOP_ST) begin
            sh = status_in >> (c - C_BANK1);
            v  = sh[0];
         end else if (c >= C_BANK2 && c < C_BANK2 + N_REF) begin
            sh = status_in >> (ST_FAULT + c - C_BANK2);
            v  = sh[0];
         end else if (c >= C_BANK3 && c < C_BANK3 + N_REF) begin
            sh = status_in >> (ST_VALID + c - C_BANK3);
            v  = sh[0];
         end else if (c >= C_BANK4 && c < C_BANK4 + N_REF) begin
            sh = status_in >> (ST_ACTV + c - C_BANK4);
            v  = sh[0];
         end
         pin_out[g] = cfg[CFG_W-1] & v;
      end
   end

endmodule

// File: rtl/mfpin_ctl_arb.sv
module mfpin_ctl_arb
   import mfpin_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic [NPINS*CFG_W-1:0] cfg_flat,
   input  logic [NPINS-1:0]       pin_sync,
   output logic [NCTL-1:0]        ctl_out
);

   logic [NCTL-1:0] tgt [NPINS];

   for (genvar g = 0; g < NPINS; g++) begin : g_tgt
      cfg_t cfg;
      assign cfg = cfg_flat[g*CFG_W +: CFG_W];
      always_comb begin
         tgt[g] = '0;
         if (!cfg[CFG_W-1]) tgt[g] = in_target(cfg[CODE_W-1:0]);
      end
   end

   // lowest index wins: scan from the top, later hits overwrite
   for (genvar k = 0; k < NCTL; k++) begin : g_ctl
      always_comb begin
         ctl_out[k] = 1'b0;
         for (int p = NPINS - 1; p >= 0; p--) begin
            if (tgt[p][k]) ctl_out[k] = pin_sync[p];
         end
      end
   end

endmodule

// File: rtl/mfpin_mux.sv
module mfpin_mux
   import mfpin_pkg::*;
#(
   parameter int NPINS     = 8,
   parameter int ADDR_W    = 3,
   parameter int SYNC_LEN  = 2,
   parameter int LOG2_DIV  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [7:0]          cfg_wdata,
   output logic [7:0]          cfg_rdata,
   input  logic [NSTAT-1:0]    status_in,
   output logic [NCTL-1:0]     ctl_out,
   input  logic [NPINS-1:0]    pin_in,
   output logic [NPINS-1:0]    pin_out,
   output logic [NPINS-1:0]    pin_oe
);

   localparam int CFG_BITS = NPINS * CFG_W;

   if (NPINS < 1 || NPINS > (1 << ADDR_W)) begin : g_bad_npins
      $error("mfpin_mux: NPINS must fit in the address space");
   end
   if (SYNC_LEN < 2) begin : g_bad_sync
      $error("mfpin_mux: SYNC_LEN must be at least 2");
   end
   if (LOG2_DIV < 1) begin : g_bad_div
      $error("mfpin_mux: LOG2_DIV must be at least 1");
   end
   if (CFG_W != 8 || CODE_W != 7) begin : g_bad_cfg
      $error("mfpin_mux: register layout must be 1 + 7 bits");
   end

   logic [CFG_BITS-1:0] cfg_flat;
   logic [NPINS-1:0]    pin_sync;
   logic                div_q;

   mfpin_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .cfg_flat (cfg_flat)
   );

   mfpin_clkdiv #(.LOG2_DIV(LOG2_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .div_q (div_q)
   );

   mfpin_sync #(.WIDTH(NPINS), .STAGES(SYNC_LEN)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   mfpin_out_sel #(.NPINS(NPINS)) u_out (
      .cfg_flat  (cfg_flat),
      .status_in (status_in),
      .div_q     (div_q),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   mfpin_ctl_arb #(.NPINS(NPINS)) u_arb (
      .cfg_flat (cfg_flat),
      .pin_sync (pin_sync),
      .ctl_out  (ctl_out)
   );

endmodule

// File: rtl/mfpin_mux_chk.sv
module mfpin_mux_chk
   import mfpin_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_we,
   input logic [ADDR_W-1:0]      cfg_addr,
   input logic [7:0]             cfg_wdata,
   input logic [7:0]             cfg_rdata,
   input logic [NCTL-1:0]        ctl_out,
   input logic [NPINS-1:0]       pin_in,
   input logic [NPINS-1:0]       pin_out,
   input logic [NPINS-1:0]       pin_oe,
   input logic [NPINS*CFG_W-1:0] cfg_flat,
   input logic                   div_q
);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 2) since_rst <= since_rst + 1'b1;
   end
   logic warm;
   assign warm = (since_rst == 2);

   assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_addr) < NPINS) ##1 (cfg_addr == $past(cfg_addr))
         |-> cfg_rdata == $past(cfg_wdata));

   assert_oe_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_addr) < NPINS) |=> pin_oe[$past(cfg_addr)] == $past(cfg_wdata[7]));

   assert_div_halfper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$stable(div_q)) |=> $stable(div_q));

   assert_idle_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (&pin_oe) |-> (ctl_out == '0));

   assert_sync_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && cfg_flat[7:0] == 8'(C_SYNC)) |-> ctl_out[CT_SYNC] == $past(pin_in[0], 2));

   assert_low_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && cfg_flat[7:0] == 8'(C_EN_BOTH) && cfg_flat[15:8] == 8'(C_BANK4))
         |-> ctl_out[CT_EN0] == $past(pin_in[0], 2));

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      assert_const0_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_flat[g*CFG_W +: CFG_W] == 8'h80) |-> !pin_out[g]);
      assert_const1_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_flat[g*CFG_W +: CFG_W] == 8'h81) |-> pin_out[g]);
   end

endmodule

bind mfpin_mux mfpin_mux_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .ctl_out   (ctl_out),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .cfg_flat  (cfg_flat),
   .div_q     (div_q)
);

// File: tb/tb_mfpin_mux.sv
module tb_mfpin_mux;

   localparam int NP = 8;
   localparam int NS = 23;
   localparam int NC = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    cfg_rdata;
   logic [NS-1:0] status_in = '0;
   logic [NC-1:0] ctl_out;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;

   int n_checks = 0;
   int n_errs   = 0;
   int ncyc     = 0;

   always #2 clk = ~clk;

   mfpin_mux dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .status_in(status_in),
      .ctl_out(ctl_out), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // edges since reset release: the divided clock is bit 4 of this count
   always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic exp_out(input int code, input logic [NS-1:0] st, input int cyc);
      if (code == 1) return 1'b1;
      if (code == 2) return 1'((cyc / 16) % 2);
      if (code >= 16 && code <= 26) return st[code - 16];
      if (code >= 32 && code <= 35) return st[code - 21];
      if (code >= 48 && code <= 51) return st[code - 33];
      if (code >= 64 && code <= 67) return st[code - 45];
      return 1'b0;
   endfunction

   function automatic logic [NC-1:0] exp_ctl(input int code);
      logic [NC-1:0] r = '0;
      if (code >= 1 && code <= 5)        r[code - 1] = 1'b1;
      else if (code >= 16 && code <= 20) r[code - 11] = 1'b1;
      else if (code >= 32 && code <= 35) r[code - 22] = 1'b1;
      else if (code >= 48 && code <= 51) r[code - 34] = 1'b1;
      else if (code == 64)               r[18] = 1'b1;
      else if (code == 65)               r[19] = 1'b1;
      else if (code == 68)               r[19:18] = 2'b11;
      else if (code == 69)               r[20] = 1'b1;
      return r;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin : main
      logic [NS-1:0] pats [2];
      pats[0] = 23'h5A3C96;
      pats[1] = ~23'h5A3C96;
      pin_in = 8'hFF;
      repeat (3) @(negedge clk);
      // R1 / R2 reset state
      for (int i = 0; i < NP; i++) begin
         cfg_addr = 3'(i); #0.5;
         check("R1 reset value", 32'(cfg_rdata), 32'h00);
      end
      check("R2 reset oe", 32'(pin_oe), 32'h0);
      check("R9 reset ctl", 32'(ctl_out), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 readback
      for (int i = 0; i < NP; i++) wr(i, 8'(8'h80 | (i * 9)));
      for (int i = 0; i < NP; i++) begin
         cfg_addr = 3'(i); #0.5;
         check("R1 readback", 32'(cfg_rdata), 32'(8'h80 | (i * 9)));
      end
      for (int i = 0; i < NP; i++) wr(i, 8'h80);

      // R3 R4 R5 R6: output sweep on every pin
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < 128; c++) begin
            wr(p, 8'(8'h80 | c));
            for (int k = 0; k < 2; k++) begin
               status_in = pats[k]; #0.5;
               check((c < 2) ? "R3 const" : (c == 2) ? "R4 div32" :
                     (exp_ctl(0) == '0 && exp_out(c, pats[0], 0) == exp_out(c, pats[1], 0) && c != 2) ? "R6 unused out" : "R5 status map",
                     32'(pin_out[p]), 32'(exp_out(c, pats[k], ncyc)));
            end
            check("R2 oe output", 32'(pin_oe[p]), 32'h1);
            check("R9 output-mode ctl", 32'(ctl_out), 32'h0);
         end
         wr(p, 8'h80);
      end

      // R4 full period on pin 3
      wr(3, 8'h82);
      for (int t = 0; t < 40; t++) begin
         check("R4 div32 period", 32'(pin_out[3]), 32'(exp_out(2, '0, ncyc)));
         @(negedge clk);
      end
      wr(3, 8'h80);

      // R7 R8 R9: input sweep on every pin, pin levels all high
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < 128; c++) begin
            wr(p, 8'(c));
            check("R2 oe input", 32'(pin_oe[p]), 32'h0);
            check((c == 68) ? "R8 dual enable" : (exp_ctl(c) == '0) ? "R9 unused in" : "R7 ctl map",
                  32'(ctl_out), 32'(exp_ctl(c)));
         end
         wr(p, 8'h80);
      end

      // R9 selected controls follow a low pin
      pin_in = 8'h00; repeat (2) @(negedge clk);
      wr(5, 8'd44); wr(5, 8'd68);
      check("R9 low level", 32'(ctl_out), 32'h0);
      wr(5, 8'h80);

      // R10 lowest index wins
      wr(3, 8'd69); wr(6, 8'd69);
      pin_in = 8'b0100_0000; repeat (2) @(negedge clk);
      check("R10 low pin wins (0)", 32'(ctl_out[20]), 32'h0);
      pin_in = 8'b0000_1000; repeat (2) @(negedge clk);
      check("R10 low pin wins (1)", 32'(ctl_out[20]), 32'h1);
      wr(2, 8'd68); wr(5, 8'd64);
      pin_in = 8'b0010_0000; repeat (2) @(negedge clk);
      check("R10 dual vs single en0", 32'(ctl_out[19:18]), 32'h0);
      pin_in = 8'b0000_0100; repeat (2) @(negedge clk);
      check("R10 dual vs single en0", 32'(ctl_out[19:18]), 32'h3);
      wr(2, 8'h80);
      check("R10 upper pin takes over", 32'(ctl_out[18]), 32'h0);
      wr(3, 8'h80); wr(5, 8'h80); wr(6, 8'h80);

      // R11 two-edge latency
      wr(1, 8'd17);
      pin_in = 8'h00; repeat (3) @(negedge clk);
      check("R11 settled low", 32'(ctl_out[6]), 32'h0);
      pin_in = 8'h02;
      @(negedge clk);
      check("R11 one edge", 32'(ctl_out[6]), 32'h0);
      @(negedge clk);
      check("R11 two edges", 32'(ctl_out[6]), 32'h1);
      pin_in = 8'h00;
      @(negedge clk);
      check("R11 fall one edge", 32'(ctl_out[6]), 32'h1);
      @(negedge clk);
      check("R11 fall two edges", 32'(ctl_out[6]), 32'h0);

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule